// File: doc/BRIEF.md
# Windowed Bit Error Rate Threshold Detector

This block decides, for protection-switching alarms, whether the line bit error rate has crossed a programmed level. An upstream parity checker supplies one error count per received frame, qualified by a one-cycle frame strobe. The block sums these counts over sub-intervals of a programmable number of frames. Each finished sub-interval is judged against a threshold. A sliding history of the judged sub-intervals then drives a declared/cleared status with hysteresis.

Two identical detectors run side by side. Firmware programs one with a warning level and the other with a fail level. Each detector has a frame-count register, a window-length register and an error-threshold register. A change in either detector's status sets a change latch. The interrupt output is the OR of the change latches, each gated by its mask bit. A status-read strobe clears the latches. Configuration is written through a write-enable, address and data port.

Top module: `ber_window_det`

## Requirements
- R1: After reset, `det_active`, `chg_flag` and `irq` are 0. Each detector defaults to a frame count of 0, a window length of 1 and a threshold of 255, and both mask bits are 0.
- R2: A write to address 4*k+f, with k the detector index 0 or 1, loads a field of detector k. Field f=0 is the 16-bit frame count from data[15:0]. Field f=1 is the 8-bit window length from data[7:0]. Field f=2 is the 8-bit threshold from data[7:0]. Address 8 loads the mask from data[1:0], with bit k belonging to detector k. Writes to any other address (f=3, or 12 to 15) change nothing.
- R3: A sub-interval lasts (frame count + 1) frame strobes. The frame errors are summed over the sub-interval. The sub-interval is flagged when the sum is at least the threshold.
- R4: The sub-interval sum saturates at 65535 and never wraps.
- R5: The window holds the flags of the most recent W sub-intervals, where W is the window length (1 to 255). A window length of 0 acts as 1.
- R6: At the end of a sub-interval, the detector's bit of `det_active` becomes 1 if twice the number of flagged sub-intervals in the window exceeds W.
- R7: At the end of a sub-interval, a declared detector becomes 0 only when no sub-interval in the window is flagged. Otherwise it keeps its state.
- R8: A write to any field of detector k restarts only that detector. Its frame position, sum, history and `det_active` bit all return to 0. The other detector is not affected.
- R9: A change of a detector's `det_active` bit sets its `chg_flag` bit on the next clock edge. This includes a change caused by a restart. `stat_rd` clears both latches, and a latch set in the same cycle as a read wins over the clear.
- R10: `irq` is 1 exactly when a `chg_flag` bit whose mask bit is 1 is set. Writing the mask does not restart either detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| frame_errs | input | 8 | Parity error count of the frame, valid with `frame_tick` |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| stat_rd | input | 1 | Status read strobe; clears change latches |
| det_active | output | 2 | Declared status, bit k for detector k |
| chg_flag | output | 2 | Change-of-state latches |
| irq | output | 1 | Masked interrupt |

## Verification
The first directed runs feed partial sums that stay one short of the threshold and then reach it exactly on the last frame. These show whether the boundary check is at-least or strictly-greater, and whether a sub-interval lasts the programmed count or one frame more. Further runs replay flag patterns that climb just past half the window and then drain one flag at a time. These separate the majority rule for declaring from the all-clear rule for clearing, including the case where window length 0 acts as 1. A run of 258 frames places the wrapped sum below the threshold, so saturation and wrap-around give different results. Random traffic mixes small error counts, reconfiguration, mask writes and status reads. It exposes cross-talk between the two detectors and set-versus-clear collisions on the change latches.

// File: rtl/ber_pkg.sv
`timescale 1ns/1ps
package ber_pkg;
  // field codes in the low two address bits of a detector's register group
  localparam logic [1:0] FLD_DENOM = 2'd0;
  localparam logic [1:0] FLD_WLEN  = 2'd1;
  localparam logic [1:0] FLD_THR   = 2'd2;
  localparam int         GRP_SPAN  = 4;
endpackage

// File: rtl/ber_cfg_regs.sv
`timescale 1ns/1ps
module ber_cfg_regs
  import ber_pkg::*;
#(
  parameter int NUM_DET = 2,
  parameter int DEN_W   = 16,
  parameter int WL_W    = 8,
  parameter int THR_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [NUM_DET-1:0][DEN_W-1:0]     denom,
  output logic [NUM_DET-1:0][WL_W-1:0]      wlen,
  output logic [NUM_DET-1:0][THR_W-1:0]     thr,
  output logic [NUM_DET-1:0]                irq_mask,
  output logic [NUM_DET-1:0]                restart
);
  localparam int SEL_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_DET * GRP_SPAN);

  logic [NUM_DET-1:0][DEN_W-1:0] denom_q, denom_d;
  logic [NUM_DET-1:0][WL_W-1:0]  wlen_q, wlen_d;
  logic [NUM_DET-1:0][THR_W-1:0] thr_q, thr_d;
  logic [NUM_DET-1:0]            mask_q, mask_d;

  always_comb begin
    denom_d = denom_q;
    wlen_d  = wlen_q;
    thr_d   = thr_q;
    mask_d  = mask_q;
    restart = '0;
    if (cfg_we) begin
      if (cfg_addr == MASK_ADDR) mask_d = cfg_wdata[NUM_DET-1:0];
      for (int i = 0; i < NUM_DET; i++) begin
        if (cfg_addr[ADDR_W-1:2] == SEL_W'(i)) begin
          case (cfg_addr[1:0])
            FLD_DENOM: begin denom_d[i] = cfg_wdata[DEN_W-1:0]; restart[i] = 1'b1; end
            FLD_WLEN:  begin wlen_d[i]  = cfg_wdata[WL_W-1:0];  restart[i] = 1'b1; end
            FLD_THR:   begin thr_d[i]   = cfg_wdata[THR_W-1:0]; restart[i] = 1'b1; end
            default:   ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DET; i++) begin
        denom_q[i] <= '0;
        wlen_q[i]  <= WL_W'(1);
        thr_q[i]   <= '1;
      end
      mask_q <= '0;
    end else begin
      denom_q <= denom_d;
      wlen_q  <= wlen_d;
      thr_q   <= thr_d;
      mask_q  <= mask_d;
    end
  end

  assign denom    = denom_q;
  assign wlen     = wlen_q;
  assign thr      = thr_q;
  assign irq_mask = mask_q;

  for (genvar g = 0; g < NUM_DET; g++) begin : g_chk
    // R2
    wlen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(g * GRP_SPAN + 1)) |=> wlen_q[g] == $past(cfg_wdata[WL_W-1:0]))
      else $error("window length not loaded");
  end
endmodule

// File: rtl/ber_detector.sv
`timescale 1ns/1ps
module ber_detector #(
  parameter int DEN_W = 16,
  parameter int WL_W  = 8,
  parameter int THR_W = 8,
  parameter int ERR_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             frame_tick,
  input  logic [ERR_W-1:0] frame_errs,
  input  logic [DEN_W-1:0] denom,
  input  logic [WL_W-1:0]  wlen,
  input  logic [THR_W-1:0] thr,
  output logic             declared
);
  localparam int HIST_N = (1 << WL_W) - 1;

  logic [DEN_W-1:0]  fcnt_q, fcnt_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [HIST_N-1:0] hist_q, hist_d;
  logic [WL_W-1:0]   cnt_q, cnt_d;
  logic              decl_q, decl_d;

  logic [WL_W-1:0]   wl_eff;
  logic [ACC_W:0]    acc_sum;
  logic [ACC_W-1:0]  acc_sat;
  logic              sub_end, flag, leaving;
  logic [WL_W-1:0]   cnt_nxt;

  always_comb begin
    wl_eff  = (wlen == '0) ? WL_W'(1) : wlen;
    acc_sum = {1'b0, acc_q} + (ACC_W+1)'(frame_errs);
    acc_sat = acc_sum[ACC_W] ? '1 : acc_sum[ACC_W-1:0];
    sub_end = frame_tick && (fcnt_q == denom);
    flag    = acc_sat >= ACC_W'(thr);
    leaving = hist_q[wl_eff - WL_W'(1)];
    cnt_nxt = cnt_q + WL_W'(flag) - WL_W'(leaving);

    fcnt_d = fcnt_q;
    acc_d  = acc_q;
    hist_d = hist_q;
    cnt_d  = cnt_q;
    decl_d = decl_q;
    if (restart) begin
      fcnt_d = '0;
      acc_d  = '0;
      hist_d = '0;
      cnt_d  = '0;
      decl_d = 1'b0;
    end else if (sub_end) begin
      fcnt_d = '0;
      acc_d  = '0;
      hist_d = {hist_q[HIST_N-2:0], flag};
      cnt_d  = cnt_nxt;
      if ({cnt_nxt, 1'b0} > {1'b0, wl_eff}) decl_d = 1'b1;
      else if (cnt_nxt == '0)               decl_d = 1'b0;
    end else if (frame_tick) begin
      fcnt_d = fcnt_q + DEN_W'(1);
      acc_d  = acc_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      acc_q  <= '0;
      hist_q <= '0;
      cnt_q  <= '0;
      decl_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      acc_q  <= acc_d;
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      decl_q <= decl_d;
    end
  end

  assign declared = decl_q;

  // R5
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= wl_eff || $past(restart) || $past(wlen) != wlen)
    else $error("flag count exceeds window");
  // R4
  acc_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !sub_end && !restart) |=> acc_q >= $past(acc_q))
    else $error("sum wrapped");
  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!decl_q && acc_q == '0 && cnt_q == '0 && fcnt_q == '0))
    else $error("restart left state");
  // R6
  decl_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decl_q) |-> $past(sub_end))
    else $error("declared away from sub-interval end");
endmodule

// File: rtl/ber_irq.sv
`timescale 1ns/1ps
module ber_irq #(
  parameter int NUM_DET = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DET-1:0] declared,
  input  logic [NUM_DET-1:0] irq_mask,
  input  logic               stat_rd,
  output logic [NUM_DET-1:0] chg_flag,
  output logic               irq
);
  logic [NUM_DET-1:0] prev_q, latch_q, latch_d, edge_v;

  always_comb begin
    edge_v  = declared ^ prev_q;
    latch_d = (stat_rd ? '0 : latch_q) | edge_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= declared;
      latch_q <= latch_d;
    end
  end

  assign chg_flag = latch_q;
  assign irq      = |(latch_q & irq_mask);

  // R9
  chg_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (declared != prev_q) |=> ((latch_q & $past(edge_v)) == $past(edge_v)))
    else $error("change not latched");
  // R9
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && declared == prev_q) |=> latch_q == '0)
    else $error("read did not clear");
endmodule

// File: rtl/ber_window_det.sv
`timescale 1ns/1ps
module ber_window_det #(
  parameter int NUM_DET = 2,
  parameter int DEN_W   = 16,
  parameter int WL_W    = 8,
  parameter int THR_W   = 8,
  parameter int ERR_W   = 8,
  parameter int ACC_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic [ERR_W-1:0]   frame_errs,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  input  logic               stat_rd,
  output logic [NUM_DET-1:0] det_active,
  output logic [NUM_DET-1:0] chg_flag,
  output logic               irq
);
  logic [NUM_DET-1:0][DEN_W-1:0] denom;
  logic [NUM_DET-1:0][WL_W-1:0]  wlen;
  logic [NUM_DET-1:0][THR_W-1:0] thr;
  logic [NUM_DET-1:0]            irq_mask;
  logic [NUM_DET-1:0]            restart;

  ber_cfg_regs #(
    .NUM_DET(NUM_DET), .DEN_W(DEN_W), .WL_W(WL_W), .THR_W(THR_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .denom(denom), .wlen(wlen), .thr(thr),
    .irq_mask(irq_mask), .restart(restart)
  );

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    ber_detector #(
      .DEN_W(DEN_W), .WL_W(WL_W), .THR_W(THR_W), .ERR_W(ERR_W), .ACC_W(ACC_W)
    ) u_det (
      .clk(clk), .rst_n(rst_n), .restart(restart[g]),
      .frame_tick(frame_tick), .frame_errs(frame_errs),
      .denom(denom[g]), .wlen(wlen[g]), .thr(thr[g]),
      .declared(det_active[g])
    );
  end

  ber_irq #(.NUM_DET(NUM_DET)) u_irq (
    .clk(clk), .rst_n(rst_n), .declared(det_active), .irq_mask(irq_mask),
    .stat_rd(stat_rd), .chg_flag(chg_flag), .irq(irq)
  );
endmodule

// File: tb/sim_ber_window_det.sv
`timescale 1ns/1ps
module sim_ber_window_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [7:0]  frame_errs = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [1:0]  det_active, chg_flag;
  logic        irq;

  ber_window_det u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .frame_errs(frame_errs),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
    .det_active(det_active), .chg_flag(chg_flag), .irq(irq)
  );

  always #4 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state, from the requirements
  int m_den[2], m_wl[2], m_thr[2], m_fcnt[2], m_acc[2];
  logic [254:0] m_hist[2];
  bit [1:0] m_decl, m_latch, m_mask;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic cmp(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check(string tag);
    cmp(tag, "det_active", det_active, m_decl);
    cmp(tag, "chg_flag", chg_flag, m_latch);
    cmp(tag, "irq", irq, (m_latch & m_mask) != 0);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_den[i] = 0; m_wl[i] = 1; m_thr[i] = 255;
      m_fcnt[i] = 0; m_acc[i] = 0; m_hist[i] = '0;
    end
    m_decl = 0; m_latch = 0; m_mask = 0;
  endtask

  function automatic bit [1:0] model_frame(int e);
    bit [1:0] chg = 0;
    for (int i = 0; i < 2; i++) begin
      bit prev = m_decl[i];
      int a = m_acc[i] + e;
      if (a > 65535) a = 65535;
      if (m_fcnt[i] == m_den[i]) begin
        int wle = (m_wl[i] == 0) ? 1 : m_wl[i];
        int c = 0;
        m_hist[i] = {m_hist[i][253:0], (a >= m_thr[i])};
        for (int k = 0; k < wle; k++) c += m_hist[i][k];
        if (2 * c > wle) m_decl[i] = 1;
        else if (c == 0) m_decl[i] = 0;
        m_fcnt[i] = 0; m_acc[i] = 0;
      end else begin
        m_fcnt[i]++; m_acc[i] = a;
      end
      chg[i] = (m_decl[i] != prev);
    end
    return chg;
  endfunction

  task automatic do_frame(int e, bit rd_after = 0);
    bit [1:0] chg;
    @(negedge clk); frame_tick = 1; frame_errs = 8'(e);
    @(negedge clk); frame_tick = 0; stat_rd = rd_after;
    chg = model_frame(e);
    @(negedge clk); stat_rd = 0;
    m_latch = (rd_after ? 2'b00 : m_latch) | chg;
  endtask

  task automatic do_write(int a, int d);
    bit [1:0] chg = 0;
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
    @(negedge clk); cfg_we = 0;
    if (a == 8) m_mask = 2'(d);
    else if (a < 8 && (a % 4) < 3) begin
      int i = a / 4;
      case (a % 4)
        0: m_den[i] = d & 16'hffff;
        1: m_wl[i]  = d & 8'hff;
        default: m_thr[i] = d & 8'hff;
      endcase
      m_fcnt[i] = 0; m_acc[i] = 0; m_hist[i] = '0;
      chg[i] = m_decl[i]; m_decl[i] = 0;
    end
    @(negedge clk);
    m_latch |= chg;
  endtask

  task automatic do_read();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    m_latch = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");
    // defaults: 1 frame per sub-interval, window 1, threshold 255
    do_frame(254); check("R1 default threshold");
    do_frame(255); check("R1 default threshold");
    do_read();     check("R9 read");

    // R3: four-frame sub-interval, threshold reached exactly on last frame
    do_write(0, 3); do_write(2, 10); do_write(1, 1); check("R8 restart");
    do_frame(3); check("R3 partial");
    do_frame(3); check("R3 partial");
    do_frame(3); check("R3 partial");
    do_frame(1); check("R3 reach");
    do_frame(2); do_frame(2); do_frame(2); do_frame(3); check("R3 one short");

    // R6 / R7: window of 4
    do_write(0, 0); do_write(2, 5); do_write(1, 4); do_read();
    do_frame(5); check("R6 one of four");
    do_frame(9); check("R6 two of four");
    do_frame(6); check("R6 three of four");
    do_frame(0); check("R7 hold");
    do_frame(1); check("R7 hold");
    do_frame(4); check("R7 hold");
    do_frame(0); check("R7 clear");
    do_frame(7); do_frame(0); check("R6 one of four again");

    // R5: window length 0 acts as 1
    do_write(1, 0);
    do_frame(5); check("R5 zero window");
    do_frame(0); check("R5 zero window");

    // R4: 257 x 255 + 1 would wrap to 0
    do_write(1, 1); do_write(2, 1); do_write(0, 257);
    for (int k = 0; k < 257; k++) do_frame(255);
    check("R4 mid sub-interval");
    do_frame(1); check("R4 saturate");

    // R8: detector 1 declared, restart detector 0 only
    do_write(4, 0); do_write(5, 1); do_write(6, 0);
    do_frame(0); check("R8 det1 declared");
    do_write(0, 0); check("R8 isolation");
    // R2: ignored addresses
    do_write(3, 16'hffff); check("R2 field 3 ignored");
    do_write(13, 0);       check("R2 address 13 ignored");
    do_write(9, 3);        check("R2 address 9 ignored");

    // R10: mask write, no restart
    do_write(8, 3); check("R10 mask");
    do_read();      check("R10 cleared");
    do_write(8, 2); check("R10 mask no restart");
    do_write(6, 200); check("R10 restart latch");
    // R9: set wins over read in the same cycle
    do_write(2, 0); do_read();
    do_frame(0, 1); check("R9 set wins");
    do_frame(0, 1); check("R9 plain clear");

    // random traffic
    for (int n = 0; n < 2500; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 82) do_frame((($urandom_range(0, 9)) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 6), $urandom_range(0, 7) == 0);
      else if (r < 90) begin
        int f = $urandom_range(0, 2);
        int d = (f == 0) ? $urandom_range(0, 3) : (f == 1) ? $urandom_range(0, 9) : $urandom_range(0, 14);
        do_write($urandom_range(0, 1) * 4 + f, d);
      end
      else if (r < 94) do_write(8, $urandom_range(0, 3));
      else if (r < 97) do_read();
      else do_write($urandom_range(0, 1) ? 3 : $urandom_range(9, 15), $urandom);
      check("R3 R6 R7 R8 R9 R10 random");
    end
    summary();
  end
endmodule